// File: doc/BRIEF.md
# Buffered Write Stall Controller

This block decides, for every CPU store, whether the CPU may continue at once or must stall until the write completes on the bus. It then runs that stall. The decision applies only to stores that bypass the cache or use write-through. A copy-back store never waits here. Where the wait-or-continue choice comes from depends on three things: the address-mode bit of a local control register, the MMU enable, and the region the store address falls in.

In the narrow 29-bit mode, one of eight per-area bits decides; each bit covers 64 Mbytes. In the wide 32-bit mode, that per-area table no longer applies. The fixed-mapping buffering bit decides for the two fixed-mapped regions. The translation-entry buffering bit decides for the user and translated regions when the MMU is on, and those regions never wait when it is off. Only the top per-area bit stays in force, and it governs the control-register region. The matching fixed-mapping and translation entries arrive already resolved on input pins.

A two-state sequencer raises the stall in the same cycle the stalling store is presented. It keeps the stall up until the bus side returns a one-cycle write-done pulse.

Top module: `wbuf_stall_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000_0000 (29-bit mode, all area bits clear) and stall_o is low.
- R2: Control register: bit 31 is the mode bit (0 = 29-bit, 1 = 32-bit wide). Bits 7:0 are area bits. Both are writable and read back on cfg_rdata_o in the cycle after the write. Bits 30:8 ignore writes and read 0.
- R3: A store with st_cached_i=1 and st_wt_i=0 (copy-back) never raises stall_o, in any mode or region.
- R4: In 29-bit mode, a bypassing store stalls if and only if area bit cfg[st_addr_i[28:26]] is 1.
- R5: In 32-bit mode, stores with st_addr_i[31:29] = 3'b100 or 3'b101 stall if and only if fix_ub_i is 1.
- R6: In 32-bit mode with mmu_en_i=1, stores with st_addr_i[31]=0 or st_addr_i[31:29]=3'b110 stall if and only if tlb_ub_i is 1.
- R7: In 32-bit mode with mmu_en_i=0, stores with st_addr_i[31]=0 or st_addr_i[31:29]=3'b110 never stall.
- R8: In 32-bit mode, stores with st_addr_i[31:29]=3'b111 stall if and only if area bit 7 is 1. Area bits 6:0 have no effect in this mode.
- R9: stall_o rises combinationally in the cycle a stalling store is presented while idle. It stays high through the cycle wr_done_i is seen, and falls in the next cycle.
- R10: While stalled, further st_valid_i stores are ignored. A wr_done_i pulse while idle is ignored and does not cut short a later stall.
- R11: A register write in the same cycle as a store does not affect that store. The store is decided on the old value, and the new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control register write data |
| cfg_rdata_o | output | 32 | Control register read value |
| st_valid_i | input | 1 | Store presented by the CPU |
| st_addr_i | input | 32 | Store address |
| st_cached_i | input | 1 | Store targets cacheable memory |
| st_wt_i | input | 1 | Cacheable store uses write-through |
| mmu_en_i | input | 1 | Address translation enabled |
| fix_ub_i | input | 1 | Buffering bit of the matching fixed-mapping entry |
| tlb_ub_i | input | 1 | Buffering bit of the matching translation entry |
| wr_done_i | input | 1 | Write-complete pulse from the bus side |
| stall_o | output | 1 | CPU stall request |

## Verification
Two functions can land in the same cycle: a control-register write and the decision for a store. The bench provokes this by driving cfg_we_i with a new mode or area value in the cycle a store is presented. It then judges that store's stall_o against the old register contents, and the store in the next cycle against the new ones. A second overlap pairs a write-done pulse with a store presented during the stall. The bench checks that the stall ends exactly one cycle after the pulse and that the extra store is ignored.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [2:0] {
    RGN_LOW = 3'd0,  // user / translated low half
    RGN_FX1 = 3'd1,  // fixed-mapped, cached
    RGN_FX2 = 3'd2,  // fixed-mapped, uncached
    RGN_TR3 = 3'd3,  // translated upper
    RGN_CTL = 3'd4   // control-register space
  } rgn_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fsm_e;

  function automatic rgn_e rgn_of(input logic [2:0] top);
    case (top)
      3'b100:  return RGN_FX1;
      3'b101:  return RGN_FX2;
      3'b110:  return RGN_TR3;
      3'b111:  return RGN_CTL;
      default: return RGN_LOW;
    endcase
  endfunction

endpackage

// File: rtl/wbuf_cfg_reg.sv
module wbuf_cfg_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AREA_N   = 8,
  parameter int unsigned MODE_BIT = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wide_mode_o,
  output logic [AREA_N-1:0] area_ub_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              mode_q;
  logic [AREA_N-1:0] ub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ub_q   <= '0;
    end else if (we_i) begin
      mode_q <= wdata_i[MODE_BIT];
      ub_q   <= wdata_i[AREA_N-1:0];
    end
  end

  // assemble read value; reserved bits tie to zero
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == MODE_BIT) begin : g_mode
      assign rdata_o[b] = mode_q;
    end else if (b < AREA_N) begin : g_ub
      assign rdata_o[b] = ub_q[b];
    end else begin : g_rsv
      assign rdata_o[b] = 1'b0;
    end
  end

  assign wide_mode_o = mode_q;
  assign area_ub_o   = ub_q;

endmodule

// File: rtl/wbuf_decide.sv
module wbuf_decide
  import wbuf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned AREA_N   = 8,
  parameter int unsigned AREA_LSB = 26
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cached_i,
  input  logic              wt_i,
  input  logic              mmu_en_i,
  input  logic              wide_mode_i,
  input  logic [AREA_N-1:0] area_ub_i,
  input  logic              fix_ub_i,
  input  logic              tlb_ub_i,
  output logic              need_stall_o
);

  localparam int unsigned IDX_W = $clog2(AREA_N);
  localparam int unsigned CTL_B = AREA_N - 1;

  logic [IDX_W-1:0] area_idx;
  rgn_e             rgn;
  logic             bypass;
  logic             narrow_ub;
  logic             wide_ub;

  assign area_idx = addr_i[AREA_LSB +: IDX_W];
  assign rgn      = rgn_of(addr_i[ADDR_W-1 -: 3]);
  assign bypass   = !cached_i || wt_i;

  assign narrow_ub = area_ub_i[area_idx];

  always_comb begin
    case (rgn)
      RGN_FX1, RGN_FX2: wide_ub = fix_ub_i;
      RGN_CTL:          wide_ub = area_ub_i[CTL_B];
      default:          wide_ub = mmu_en_i & tlb_ub_i;
    endcase
  end

  assign need_stall_o = bypass && (wide_mode_i ? wide_ub : narrow_ub);

endmodule

// File: rtl/wbuf_fsm.sv
module wbuf_fsm
  import wbuf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic store_i,
  input  logic need_i,
  input  logic done_i,
  output logic stall_o,
  output logic wait_o
);

  fsm_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (store_i && need_i) state_d = ST_WAIT;
      ST_WAIT: if (done_i)            state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign wait_o  = (state_q == ST_WAIT);
  // raise in the accept cycle, hold through the done cycle
  assign stall_o = wait_o || (store_i && need_i);

endmodule

// File: rtl/wbuf_stall_ctrl.sv
module wbuf_stall_ctrl #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AREA_N   = 8,
  parameter int unsigned AREA_LSB = 26,
  parameter int unsigned MODE_BIT = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              st_cached_i,
  input  logic              st_wt_i,
  input  logic              mmu_en_i,
  input  logic              fix_ub_i,
  input  logic              tlb_ub_i,
  input  logic              wr_done_i,
  output logic              stall_o
);

  logic              wide_mode;
  logic [AREA_N-1:0] area_ub;
  logic              need_stall;
  logic              wait_q;

  wbuf_cfg_reg #(
    .DATA_W  (DATA_W),
    .AREA_N  (AREA_N),
    .MODE_BIT(MODE_BIT)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .wide_mode_o(wide_mode),
    .area_ub_o  (area_ub),
    .rdata_o    (cfg_rdata_o)
  );

  wbuf_decide #(
    .ADDR_W  (ADDR_W),
    .AREA_N  (AREA_N),
    .AREA_LSB(AREA_LSB)
  ) u_dec (
    .addr_i      (st_addr_i),
    .cached_i    (st_cached_i),
    .wt_i        (st_wt_i),
    .mmu_en_i    (mmu_en_i),
    .wide_mode_i (wide_mode),
    .area_ub_i   (area_ub),
    .fix_ub_i    (fix_ub_i),
    .tlb_ub_i    (tlb_ub_i),
    .need_stall_o(need_stall)
  );

  wbuf_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .store_i(st_valid_i),
    .need_i (need_stall),
    .done_i (wr_done_i),
    .stall_o(stall_o),
    .wait_o (wait_q)
  );

endmodule

// File: rtl/wbuf_stall_chk.sv
module wbuf_stall_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AREA_N = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic              st_valid_i,
  input logic [ADDR_W-1:0] st_addr_i,
  input logic              st_cached_i,
  input logic              st_wt_i,
  input logic              mmu_en_i,
  input logic              wr_done_i,
  input logic              stall_o,
  input logic              wait_q
);

  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[DATA_W-2:AREA_N] == '0);

  // R3
  copyback_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && st_valid_i && st_cached_i && !st_wt_i) |-> !stall_o);

  // R7
  wide_mmu_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && st_valid_i && cfg_rdata_o[DATA_W-1] && !mmu_en_i &&
     (!st_addr_i[ADDR_W-1] || st_addr_i[ADDR_W-1 -: 3] == 3'b110)) |-> !stall_o);

  // R9
  stall_needs_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !wait_q) |-> st_valid_i);

  // R9
  hold_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !wr_done_i) |=> stall_o);

  // R9
  release_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && wr_done_i) |=> !wait_q);

endmodule

bind wbuf_stall_ctrl wbuf_stall_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .AREA_N(AREA_N)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_rdata_o(cfg_rdata_o),
  .st_valid_i (st_valid_i),
  .st_addr_i  (st_addr_i),
  .st_cached_i(st_cached_i),
  .st_wt_i    (st_wt_i),
  .mmu_en_i   (mmu_en_i),
  .wr_done_i  (wr_done_i),
  .stall_o    (stall_o),
  .wait_q     (wait_q)
);

// File: tb/wbuf_stall_ctrl_tb.sv
module wbuf_stall_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        st_cached = 1'b0;
  logic        st_wt = 1'b0;
  logic        mmu_en = 1'b0;
  logic        fix_ub = 1'b0;
  logic        tlb_ub = 1'b0;
  logic        wr_done = 1'b0;
  logic        stall;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [31:0] cfg_m = '0;  // bench copy of the register

  localparam logic [31:0] CFG_MASK = 32'h8000_00FF;

  always #10 clk = ~clk;  // 50 MHz

  wbuf_stall_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_cached_i(st_cached),
    .st_wt_i(st_wt), .mmu_en_i(mmu_en), .fix_ub_i(fix_ub), .tlb_ub_i(tlb_ub),
    .wr_done_i(wr_done), .stall_o(stall)
  );

  function automatic bit model(input logic [31:0] a, input bit c, input bit w,
                               input bit m, input bit f, input bit t,
                               input logic [31:0] cfg);
    if (c && !w) return 1'b0;
    if (!cfg[31]) return cfg[a[28:26]];
    case (a[31:29])
      3'b100, 3'b101: return f;
      3'b111:         return cfg[7];
      default:        return m & t;
    endcase
  endfunction

  function automatic string tag(input logic [31:0] a, input bit c, input bit w,
                                input bit m, input logic [31:0] cfg);
    if (c && !w) return "R3";
    if (!cfg[31]) return "R4";
    case (a[31:29])
      3'b100, 3'b101: return "R5";
      3'b111:         return "R8";
      default:        return m ? "R6" : "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = d & CFG_MASK;
    #5 chk("R2", cfg_rdata, cfg_m);
  endtask

  // present one store; if it stalls, wait, then complete with wr_done
  task automatic store(input logic [31:0] a, input bit c, input bit w,
                       input bit m, input bit f, input bit t, input int gap);
    bit e;
    e = model(a, c, w, m, f, t, cfg_m);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_cached = c; st_wt = w;
    mmu_en = m; fix_ub = f; tlb_ub = t;
    #5 chk(tag(a, c, w, m, cfg_m), {31'b0, stall}, {31'b0, e});
    @(negedge clk);
    if (e) begin
      // R10: a copy-back store during the stall is ignored
      st_addr = 32'h0000_1000; st_cached = 1'b1; st_wt = 1'b0;
      for (int k = 0; k < gap; k++) begin
        #5 chk("R9", {31'b0, stall}, 32'd1);
        @(negedge clk);
        st_valid = 1'b0;
      end
      st_valid = 1'b0;
      wr_done = 1'b1;
      #5 chk("R9", {31'b0, stall}, 32'd1);
      @(negedge clk);
      wr_done = 1'b0;
      #5 chk("R9", {31'b0, stall}, 32'd0);
    end else begin
      st_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #3;
    // R1
    chk("R1", cfg_rdata, 32'h0);
    chk("R1", {31'b0, stall}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", cfg_rdata, 32'h0);

    // R2: reserved bits ignore writes
    cfg_write(32'hFFFF_FFFF);
    cfg_write(32'h7FFF_FF00);
    cfg_write(32'h0000_0024);

    // R4: area bits 2 and 5 set
    store(32'h0800_0000, 0, 0, 0, 0, 0, 0);  // area 2 -> stall
    store(32'h1400_0000, 0, 1, 0, 1, 1, 2);  // area 5, write-through
    store(32'h0400_0000, 0, 0, 1, 1, 1, 0);  // area 1 -> no stall
    store(32'h8800_0000, 1, 0, 0, 0, 0, 0);  // R3 copy-back

    // R10: done while idle is ignored
    @(negedge clk); wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
    store(32'h0800_0000, 0, 0, 0, 0, 0, 1);

    // R8: wide mode, bit 7 clear, bits 6:0 set -> no stall anywhere they used to
    cfg_write(32'h8000_007F);
    store(32'hFC00_0000, 0, 0, 0, 0, 0, 0);  // R8 -> 0
    store(32'h0800_0000, 0, 0, 0, 0, 0, 0);  // R7 -> 0
    store(32'h8000_0000, 0, 0, 0, 1, 0, 1);  // R5 -> 1
    store(32'hA000_0000, 0, 0, 1, 0, 1, 0);  // R5 -> 0
    store(32'hC000_0000, 0, 0, 1, 0, 1, 1);  // R6 -> 1
    store(32'h4000_0000, 0, 0, 0, 1, 1, 0);  // R7 -> 0
    cfg_write(32'h8000_0080);
    store(32'hFC00_0000, 0, 1, 0, 0, 0, 1);  // R8 -> 1

    // R11: write coincident with a store; the store sees the old value
    cfg_write(32'h0000_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0001;
    st_valid = 1'b1; st_addr = 32'h0000_0040; st_cached = 1'b0; st_wt = 1'b0;
    #5 chk("R11", {31'b0, stall}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; cfg_m = 32'h0000_0001;
    #5 chk("R11", {31'b0, stall}, 32'd1);
    @(negedge clk);
    st_valid = 1'b0; wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    #5 chk("R9", {31'b0, stall}, 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      if (i % 37 == 0) cfg_write($urandom());
      a = $urandom();
      store(a, 1'($urandom()), 1'($urandom()), 1'($urandom()),
            1'($urandom()), 1'($urandom()), int'($urandom_range(0, 3)));
    end

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule